// File: doc/BRIEF.md
# Periodic temperature sampler with averaging filter

This block polls an on-die temperature sensor on a programmable microsecond schedule. Each reading it accepts can go through a fixed filter that averages the previous result and the new sample with equal weight, or it can go straight through unchanged. The result is then expressed as a signed distance from a programmable activation threshold. That distance is never positive and approaches zero as the die heats toward the threshold.

A polling host reads the registered relative value and uses a one-cycle strobe to see fresh results. A thermal-control request asserts when the distance reaches zero. The analog sensor, the host's serial link and any fan policy sit outside this block.

Top module: `temp_poll_filter`

## Requirements
- R1: With the filter on and primed, each accepted reading updates the filter state to floor((state + reading) / 2), computed at full width on two's-complement values.
- R2: The first reading accepted after reset, and the first one after the filter is switched back on, loads the filter state directly with no averaging.
- R3: With cfg_filter_en low, each accepted reading becomes the filter state unchanged.
- R4: Requests start every N microseconds, with one microsecond equal to CLK_PER_US clocks. N is cfg_interval_us, and the value 0 selects the 82 us default. The first interval after reset is 82 us.
- R5: A cfg_interval_us value above 20000 behaves as 20000.
- R6: A new cfg_interval_us value is picked up only when an interval begins. An interval already running keeps its length.
- R7: rel_temp is an 8-bit two's-complement value equal to (filter state − cfg_threshold), limited to the range −128..0.
- R8: therm_ctl is high exactly while rel_temp equals zero.
- R9: rel_upd is a one-clock pulse in the cycle after a reading is accepted, and rel_temp changes only with it. rel_upd is never high while sens_req is high.
- R10: A reading is accepted only when sens_valid is high while sens_req is high. sens_req stays high until then. sens_valid without a pending request changes nothing. An interval that ends while a request is still waiting issues no second request.
- R11: After reset, sens_req and rel_upd are low, therm_ctl is low and rel_temp is −128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval_us | input | INT_W | Sample interval in microseconds (0 = default) |
| cfg_filter_en | input | 1 | Averaging filter enable |
| cfg_threshold | input | RAW_W | Signed activation threshold |
| sens_req | output | 1 | Sample request to the sensor |
| sens_valid | input | 1 | Sensor reading valid |
| sens_data | input | RAW_W | Signed raw reading |
| rel_temp | output | 8 | Signed distance below the activation point |
| rel_upd | output | 1 | One-cycle refresh strobe |
| therm_ctl | output | 1 | Thermal-control request |

## Verification
The hardest case to reach from the ports is the interval clamp at 20000 us, because it needs tens of thousands of cycles before the effect shows. The bench reduces CLK_PER_US to 2, so the clamped interval becomes one 40000-cycle gap. It times the rising edges of successive requests while changing the interval just after an edge, which also shows that a running interval keeps its length. Priming after re-enable is reached by switching the filter off for two samples in the middle of the vector walk.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int DEFAULT_US = 82;
  localparam int MAX_US     = 20000;
  localparam int REL_W      = 8;
  typedef logic signed [REL_W-1:0] rel_t;
endpackage

// File: rtl/tsf_interval_timer.sv
module tsf_interval_timer #(
  parameter int CLK_PER_US = 4,
  parameter int INT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] cfg_us,
  output logic             interval_start,
  output logic [INT_W-1:0] cur_int
);
  import tsf_pkg::*;
  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  function automatic logic [INT_W-1:0] eff_interval(input logic [INT_W-1:0] v);
    if (v == '0)                 return INT_W'(DEFAULT_US);
    else if (v > INT_W'(MAX_US)) return INT_W'(MAX_US);
    else                         return v;
  endfunction

  logic [DIV_W-1:0] div_q;
  logic [INT_W-1:0] cnt_q;
  logic             us_tick;

  assign us_tick        = (div_q == DIV_W'(CLK_PER_US - 1));
  assign interval_start = us_tick && (cnt_q == cur_int - INT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      cnt_q   <= '0;
      cur_int <= INT_W'(DEFAULT_US);
    end else begin
      div_q <= us_tick ? '0 : div_q + DIV_W'(1);
      if (us_tick) begin
        if (interval_start) begin
          cnt_q   <= '0;
          cur_int <= eff_interval(cfg_us);
        end else begin
          cnt_q <= cnt_q + INT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tsf_avg_filter.sv
module tsf_avg_filter #(
  parameter int W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                load,
  input  logic signed [W-1:0] raw,
  output logic signed [W-1:0] filt_next,
  output logic signed [W-1:0] filt_q
);
  function automatic logic signed [W-1:0] half_sum(input logic signed [W-1:0] a,
                                                   input logic signed [W-1:0] b);
    logic signed [W:0] s;
    s = $signed({a[W-1], a}) + $signed({b[W-1], b});
    return s[W:1];
  endfunction

  logic primed_q;

  always_comb begin
    if (en && primed_q) filt_next = half_sum(filt_q, raw);
    else                filt_next = raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      if (load) filt_q <= filt_next;
      if (!en)       primed_q <= 1'b0;
      else if (load) primed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tsf_rel_stage.sv
module tsf_rel_stage #(
  parameter int W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  logic signed [W-1:0] val,
  input  logic signed [W-1:0] thr,
  output tsf_pkg::rel_t       rel_temp,
  output logic                rel_upd,
  output logic                therm_ctl
);
  import tsf_pkg::*;

  function automatic rel_t rel_sat(input logic signed [W-1:0] v,
                                   input logic signed [W-1:0] t);
    logic signed [W:0] d;
    d = $signed({v[W-1], v}) - $signed({t[W-1], t});
    if (d > $signed((W+1)'(0)))          return '0;
    else if (d < $signed((W+1)'(-128)))  return rel_t'(-128);
    else                                 return d[REL_W-1:0];
  endfunction

  rel_t rel_next;
  assign rel_next = rel_sat(val, thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_temp  <= rel_t'(-128);
      rel_upd   <= 1'b0;
      therm_ctl <= 1'b0;
    end else begin
      rel_upd <= upd;
      if (upd) begin
        rel_temp  <= rel_next;
        therm_ctl <= (rel_next == '0);
      end
    end
  end
endmodule

// File: rtl/temp_poll_filter.sv
module temp_poll_filter #(
  parameter int CLK_PER_US = 4,
  parameter int INT_W      = 16,
  parameter int RAW_W      = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [INT_W-1:0]        cfg_interval_us,
  input  logic                    cfg_filter_en,
  input  logic signed [RAW_W-1:0] cfg_threshold,
  output logic                    sens_req,
  input  logic                    sens_valid,
  input  logic signed [RAW_W-1:0] sens_data,
  output logic signed [7:0]       rel_temp,
  output logic                    rel_upd,
  output logic                    therm_ctl
);
  logic                    interval_start;
  logic [INT_W-1:0]        cur_int;
  logic                    accept;
  logic                    defer_q;
  logic signed [RAW_W-1:0] filt_next;
  logic signed [RAW_W-1:0] filt_q;

  assign accept = sens_req && sens_valid;

  tsf_interval_timer #(.CLK_PER_US(CLK_PER_US), .INT_W(INT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .cfg_us(cfg_interval_us),
    .interval_start(interval_start), .cur_int(cur_int)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sens_req <= 1'b0;
      defer_q  <= 1'b0;
    end else begin
      defer_q <= interval_start && accept;
      if (accept)                                     sens_req <= 1'b0;
      else if ((interval_start && !sens_req) || defer_q) sens_req <= 1'b1;
    end
  end

  tsf_avg_filter #(.W(RAW_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .en(cfg_filter_en), .load(accept),
    .raw(sens_data), .filt_next(filt_next), .filt_q(filt_q)
  );

  tsf_rel_stage #(.W(RAW_W)) u_rel (
    .clk(clk), .rst_n(rst_n), .upd(accept), .val(filt_next),
    .thr(cfg_threshold), .rel_temp(rel_temp), .rel_upd(rel_upd),
    .therm_ctl(therm_ctl)
  );
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker (
  input logic              clk,
  input logic              rst_n,
  input logic              sens_req,
  input logic              sens_valid,
  input logic              rel_upd,
  input logic signed [7:0] rel_temp,
  input logic              therm_ctl
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sens_req && !sens_valid) |=> sens_req);
  p_upd_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sens_req && sens_valid) |=> rel_upd);
  p_upd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_upd |=> !rel_upd);
  p_upd_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_upd |-> !sens_req);
  p_rel_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_upd |-> $stable(rel_temp));
  p_rel_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_temp <= 8'sd0);
  p_ctl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    therm_ctl == (rel_temp == 8'sd0));
endmodule

bind temp_poll_filter tsf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sens_req(sens_req), .sens_valid(sens_valid),
  .rel_upd(rel_upd), .rel_temp(rel_temp), .therm_ctl(therm_ctl)
);

// File: tb/temp_poll_filter_tb.sv
module temp_poll_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int NV         = 15;
  localparam int V_RAW [NV] = '{60, 80, 81, 100, 130, 100, -101, -4, -200, 100, 50, 51, 52, 20, 19};
  localparam int V_EN  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 1, 1, 1, 0, 0};
  localparam int V_THR [NV] = '{100, 100, 100, 100, 100, 100, 100, 100, 100, 100, 100, 100, 100, 20, 20};
  localparam int V_EXP [NV] = '{-40, -30, -25, -13, 0, 0, -99, -102, -128, 0, -50, -50, -49, 0, -1};

  logic clk = 0;
  logic rst_n = 0;
  logic [15:0] cfg_interval_us = '0;
  logic cfg_filter_en = 1;
  logic signed [9:0] cfg_threshold = 10'sd100;
  logic sens_req;
  logic sens_valid = 0;
  logic signed [9:0] sens_data = '0;
  logic signed [7:0] rel_temp;
  logic rel_upd;
  logic therm_ctl;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nrise = 0;
  int rise_t [8];
  int overlap = 0;
  logic prev_req = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_poll_filter #(.CLK_PER_US(CPU), .INT_W(16), .RAW_W(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_interval_us(cfg_interval_us),
    .cfg_filter_en(cfg_filter_en), .cfg_threshold(cfg_threshold),
    .sens_req(sens_req), .sens_valid(sens_valid), .sens_data(sens_data),
    .rel_temp(rel_temp), .rel_upd(rel_upd), .therm_ctl(therm_ctl)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_req <= sens_req;
    if (rst_n && sens_req && !prev_req && nrise < 8) begin
      rise_t[nrise] <= cyc;
      nrise <= nrise + 1;
    end
    if (rst_n && rel_upd && sens_req) overlap <= overlap + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    sens_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    nrise = 0;
    @(negedge clk);
  endtask

  task automatic serve(input int raw);
    @(negedge clk);
    while (!sens_req) @(negedge clk);
    @(negedge clk);
    sens_valid = 1;
    sens_data = 10'(raw);
    @(negedge clk);
    sens_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R11 reset state
    cfg_interval_us = 16'd0;
    do_reset();
    chk(sens_req == 0, "R11 sens_req", int'(sens_req), 0);
    chk(rel_upd == 0, "R11 rel_upd", int'(rel_upd), 0);
    chk(therm_ctl == 0, "R11 therm_ctl", int'(therm_ctl), 0);
    chk(rel_temp == -8'sd128, "R11 rel_temp", int'(rel_temp), -128);

    // R4 default, R6 change at interval start, R5 clamp
    serve(0);
    serve(0);
    cfg_interval_us = 16'd10;
    serve(0);
    serve(0);
    cfg_interval_us = 16'd30000;
    serve(0);
    serve(0);
    chk(rise_t[1] - rise_t[0] == 82*CPU, "R4 default gap", rise_t[1] - rise_t[0], 82*CPU);
    chk(rise_t[2] - rise_t[1] == 82*CPU, "R6 running interval kept", rise_t[2] - rise_t[1], 82*CPU);
    chk(rise_t[3] - rise_t[2] == 10*CPU, "R4 programmed gap", rise_t[3] - rise_t[2], 10*CPU);
    chk(rise_t[4] - rise_t[3] == 10*CPU, "R6 old value until start", rise_t[4] - rise_t[3], 10*CPU);
    chk(rise_t[5] - rise_t[4] == 20000*CPU, "R5 clamp gap", rise_t[5] - rise_t[4], 20000*CPU);

    // Vector walk: R1 R2 R3 R7 R8 R9
    cfg_interval_us = 16'd5;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      cfg_filter_en = V_EN[i][0];
      cfg_threshold = 10'(V_THR[i]);
      serve(V_RAW[i]);
      chk(rel_upd == 1, "R9 strobe", int'(rel_upd), 1);
      chk(int'(rel_temp) == V_EXP[i], "R1/R2/R3/R7 rel_temp", int'(rel_temp), V_EXP[i]);
      chk(therm_ctl == (V_EXP[i] == 0), "R8 therm_ctl", int'(therm_ctl), int'(V_EXP[i] == 0));
    end

    // R10 valid without request is ignored
    sens_data = 10'sd0;
    sens_valid = 1;
    @(negedge clk);
    sens_valid = 0;
    chk(rel_upd == 0 && sens_req == 0, "R10 no strobe", int'(rel_upd), 0);
    @(negedge clk);
    chk(rel_temp == -8'sd1, "R10 rel_temp held", int'(rel_temp), -1);
    chk(overlap == 0, "R9 strobe with request", overlap, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule